// File: doc/BRIEF.md
# Two-Phase Link Training Sequencer

This block runs the link-training handshake for a serial display link after the rate and lane count have been chosen. It first runs a clock-recovery phase with training pattern 1. In that phase it repeatedly asks an external drive-level matcher to apply new drive settings, waits a set number of microsecond ticks, and asks an external status reader for the six sink status bytes. Once every active lane reports clock recovery, it moves to pattern 2. It then repeats a wait, read, evaluate and commit loop until the lanes report equalisation and symbol lock with interlane alignment. On either outcome it drives the pattern back to 0.

Control logic starts a run with a one-cycle `start` pulse and the number of active lanes. The sequencer issues single-cycle `commit_req` and `rd_req` strobes. It holds its state until the matching acknowledge arrives, and an acknowledge may carry an error flag. The run ends with a one-cycle `done` pulse. At that pulse `pass` shows the result, and `pass` holds that value until the next start.

Top module: `ltrain_seq`

## Requirements
- R1: A `start` pulse while idle sets `pattern` to 1 in the next cycle, and the first request of the run is a commit.
- R2: Each clock-recovery iteration is a commit, then a wait of `CR_WAIT_US` ticks of `us_tick` counted after the commit acknowledge, then a status read.
- R3: Lane i's status nibble is bits `[(i&1)*4 +: 4]` of status byte `i>>1`, where byte k is `rd_data[8k +: 8]`. Nibble bit 0 means clock recovered. When every active lane shows bit 0 after a clock-recovery read, `pattern` becomes 2.
- R4: Clock recovery aborts with a fail if the lowest-numbered active lane lacking bit 0 has its max-swing flag set in `cfg_maxsw`, as returned by the latest commit. Max-swing flags of other lanes have no effect.
- R5: The clock-recovery try count restarts whenever `cfg_swing0` differs from its value at the previous evaluation, which starts at 0. The phase fails once `CR_MAX_TRIES` evaluations have passed with no change.
- R6: Each equalisation iteration is a wait of `EQ_WAIT_US` ticks, then a status read, then a commit.
- R7: Equalisation succeeds only when bit 0 of status byte 2 (interlane aligned) is set and every active lane shows nibble bit 1 (equalised) and bit 2 (symbol locked). The commit of that iteration is still issued before the pass.
- R8: If any active lane lacks nibble bit 0 in an equalisation read, the run fails after that iteration's commit.
- R9: Equalisation runs at most `EQ_MAX_ITERS` (6) iterations before failing.
- R10: Every run ends with `pattern` at 0 and a one-cycle `done`, with `pass` high only if both phases succeeded.
- R11: An acknowledge that carries an error, on either commit or read, ends the run at once with a fail.
- R12: Status nibbles of lanes at or above `lane_num` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a training run (idle only) |
| lane_num | input | 3 | Active lane count, 1..MAX_LANES, sampled at start |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| commit_req | output | 1 | Strobe: matcher should apply drive settings |
| commit_ack | input | 1 | Matcher finished |
| commit_err | input | 1 | Matcher reported an error (with ack) |
| cfg_swing0 | input | 2 | Lane 0 swing level chosen (with ack) |
| cfg_maxsw | input | MAX_LANES | Per-lane max-swing flags (with ack) |
| rd_req | output | 1 | Strobe: read six status bytes |
| rd_ack | input | 1 | Status read finished |
| rd_err | input | 1 | Status read error (with ack) |
| rd_data | input | 48 | Status bytes, byte k at [8k+7:8k] |
| pattern | output | 2 | Training pattern to drive: 0 off, 1, 2 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last run |

## Verification
Some properties are checked on every cycle. The pattern only ever steps from 1 to 2 and is 0 whenever `done` is high. A start moves the pattern to 1. At most one of the two strobes and the done pulse is active in any cycle. Either error acknowledge leads two cycles later to a failing `done`. The loop behaviour can only be shown by the bench's scripted scenarios, because it depends on the status and swing values fed back over several iterations. This covers the try-count restart on a swing change, the abort on a max-swing lane, the six-iteration limit for equalisation, ignored lanes, and the wait lengths between requests.

// File: rtl/ltrain_pkg.sv
package ltrain_pkg;

   localparam int unsigned STAT_BYTES = 6;
   localparam int unsigned STAT_W     = 8 * STAT_BYTES;
   localparam int unsigned ALIGN_BIT  = 16;

   localparam logic [1:0] PAT_OFF = 2'd0;
   localparam logic [1:0] PAT_CLK = 2'd1;
   localparam logic [1:0] PAT_EQ  = 2'd2;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CR_CMT,
      ST_CR_CMT_W,
      ST_CR_WAIT,
      ST_CR_RD,
      ST_CR_RD_W,
      ST_CR_EVAL,
      ST_EQ_WAIT,
      ST_EQ_RD,
      ST_EQ_RD_W,
      ST_EQ_EVAL,
      ST_EQ_CMT,
      ST_EQ_CMT_W,
      ST_FINISH
   } seq_state_e;

   typedef struct packed {
      logic cr_all;
      logic eq_all;
      logic abort_swing;
      logic cr_lost;
   } lane_verdict_t;

endpackage

// File: rtl/ltrain_wait.sv
module ltrain_wait #(
   parameter int unsigned CR_US = 100,
   parameter int unsigned EQ_US = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sel_eq,
   input  logic tick,
   output logic expired
);
   localparam int unsigned MAX_US = (EQ_US > CR_US) ? EQ_US : CR_US;
   localparam int unsigned CNT_W  = $clog2(MAX_US + 1);
   localparam logic [CNT_W-1:0] CR_LIM = CNT_W'(CR_US);
   localparam logic [CNT_W-1:0] EQ_LIM = CNT_W'(EQ_US);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   assign limit = sel_eq ? EQ_LIM : CR_LIM;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en) begin
         cnt_q <= '0;
      end else if (tick && (cnt_q != limit)) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign expired = en && (cnt_q == limit);

endmodule

// File: rtl/ltrain_lane_eval.sv
module ltrain_lane_eval
   import ltrain_pkg::*;
#(
   parameter int unsigned MAX_LANES = 4,
   parameter int unsigned LN_W      = 3
) (
   input  logic [STAT_W-1:0]    stat,
   input  logic [LN_W-1:0]      lanes,
   input  logic [MAX_LANES-1:0] maxsw,
   output lane_verdict_t        verdict
);
   logic [MAX_LANES-1:0] cr_ok;
   logic [MAX_LANES-1:0] eq_ok;
   logic                 abort_c;
   logic                 unused_bits;

   for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
      localparam int unsigned BASE = (g >> 1) * 8 + (g & 1) * 4;
      logic active;
      assign active   = (g < int'(lanes));
      assign cr_ok[g] = !active || stat[BASE];
      assign eq_ok[g] = !active || (stat[BASE+1] && stat[BASE+2]);
   end

   always_comb begin
      logic found;
      found   = 1'b0;
      abort_c = 1'b0;
      for (int i = 0; i < MAX_LANES; i++) begin
         if (!found && !cr_ok[i]) begin
            found   = 1'b1;
            abort_c = maxsw[i];
         end
      end
   end

   assign unused_bits = ^{stat[STAT_W-1:ALIGN_BIT+1], stat[ALIGN_BIT-1:0]};

   assign verdict.cr_all      = &cr_ok;
   assign verdict.eq_all      = stat[ALIGN_BIT] && (&eq_ok);
   assign verdict.abort_swing = abort_c;
   assign verdict.cr_lost     = !(&cr_ok);

endmodule

// File: rtl/ltrain_seq.sv
module ltrain_seq
   import ltrain_pkg::*;
#(
   parameter int unsigned MAX_LANES    = 4,
   parameter int unsigned SWING_W      = 2,
   parameter int unsigned CR_WAIT_US   = 100,
   parameter int unsigned EQ_WAIT_US   = 400,
   parameter int unsigned CR_MAX_TRIES = 5,
   parameter int unsigned EQ_MAX_ITERS = 6,
   localparam int unsigned LN_W        = $clog2(MAX_LANES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [LN_W-1:0]      lane_num,
   input  logic                 us_tick,
   output logic                 commit_req,
   input  logic                 commit_ack,
   input  logic                 commit_err,
   input  logic [SWING_W-1:0]   cfg_swing0,
   input  logic [MAX_LANES-1:0] cfg_maxsw,
   output logic                 rd_req,
   input  logic                 rd_ack,
   input  logic                 rd_err,
   input  logic [47:0]          rd_data,
   output logic [1:0]           pattern,
   output logic                 busy,
   output logic                 done,
   output logic                 pass
);
   localparam int unsigned TRY_MAX = (CR_MAX_TRIES > EQ_MAX_ITERS) ? CR_MAX_TRIES : EQ_MAX_ITERS;
   localparam int unsigned TRY_W   = $clog2(TRY_MAX + 1);

   if (MAX_LANES < 1 || MAX_LANES > 4) begin : g_bad_lanes
      $error("MAX_LANES must be within 1..4 (status bytes 0..1 hold lane nibbles)");
   end
   if (CR_MAX_TRIES < 1 || EQ_MAX_ITERS < 1) begin : g_bad_tries
      $error("try limits must be at least 1");
   end
   if (CR_WAIT_US < 1 || EQ_WAIT_US < 1) begin : g_bad_wait
      $error("wait lengths must be at least 1 tick");
   end

   seq_state_e           state;
   logic [1:0]           pat_q;
   logic [TRY_W-1:0]     tries_q;
   logic [TRY_W-1:0]     cr_next_try;
   logic [SWING_W-1:0]   prev_sw_q;
   logic [SWING_W-1:0]   sw_q;
   logic [MAX_LANES-1:0] msw_q;
   logic [STAT_W-1:0]    stat_q;
   logic [LN_W-1:0]      lanes_q;
   logic                 eq_ok_q;
   logic                 cr_lost_q;
   logic                 ok_q;
   logic                 done_q;
   logic                 pass_q;
   logic                 wait_en;
   logic                 wait_over;
   lane_verdict_t        verdict;

   assign wait_en = (state == ST_CR_WAIT) || (state == ST_EQ_WAIT);

   ltrain_wait #(
      .CR_US (CR_WAIT_US),
      .EQ_US (EQ_WAIT_US)
   ) wait_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (wait_en),
      .sel_eq  (state == ST_EQ_WAIT),
      .tick    (us_tick),
      .expired (wait_over)
   );

   ltrain_lane_eval #(
      .MAX_LANES (MAX_LANES),
      .LN_W      (LN_W)
   ) eval_i (
      .stat    (stat_q),
      .lanes   (lanes_q),
      .maxsw   (msw_q),
      .verdict (verdict)
   );

   assign cr_next_try = (sw_q != prev_sw_q) ? TRY_W'(1) : tries_q + TRY_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pat_q     <= PAT_OFF;
         tries_q   <= '0;
         prev_sw_q <= '0;
         sw_q      <= '0;
         msw_q     <= '0;
         stat_q    <= '0;
         lanes_q   <= '0;
         eq_ok_q   <= 1'b0;
         cr_lost_q <= 1'b0;
         ok_q      <= 1'b0;
         done_q    <= 1'b0;
         pass_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  pat_q     <= PAT_CLK;
                  tries_q   <= '0;
                  prev_sw_q <= '0;
                  ok_q      <= 1'b0;
                  pass_q    <= 1'b0;
                  lanes_q   <= lane_num;
                  state     <= ST_CR_CMT;
               end
            end
            ST_CR_CMT: state <= ST_CR_CMT_W;
            ST_CR_CMT_W: begin
               if (commit_ack) begin
                  if (commit_err) begin
                     state <= ST_FINISH;
                  end else begin
                     sw_q  <= cfg_swing0;
                     msw_q <= cfg_maxsw;
                     state <= ST_CR_WAIT;
                  end
               end
            end
            ST_CR_WAIT: if (wait_over) state <= ST_CR_RD;
            ST_CR_RD:   state <= ST_CR_RD_W;
            ST_CR_RD_W: begin
               if (rd_ack) begin
                  if (rd_err) begin
                     state <= ST_FINISH;
                  end else begin
                     stat_q <= rd_data;
                     state  <= ST_CR_EVAL;
                  end
               end
            end
            ST_CR_EVAL: begin
               prev_sw_q <= sw_q;
               if (verdict.cr_all) begin
                  pat_q   <= PAT_EQ;
                  tries_q <= '0;
                  state   <= ST_EQ_WAIT;
               end else if (verdict.abort_swing) begin
                  state <= ST_FINISH;
               end else if (int'(cr_next_try) >= int'(CR_MAX_TRIES)) begin
                  state <= ST_FINISH;
               end else begin
                  tries_q <= cr_next_try;
                  state   <= ST_CR_CMT;
               end
            end
            ST_EQ_WAIT: if (wait_over) state <= ST_EQ_RD;
            ST_EQ_RD:   state <= ST_EQ_RD_W;
            ST_EQ_RD_W: begin
               if (rd_ack) begin
                  if (rd_err) begin
                     state <= ST_FINISH;
                  end else begin
                     stat_q <= rd_data;
                     state  <= ST_EQ_EVAL;
                  end
               end
            end
            ST_EQ_EVAL: begin
               eq_ok_q   <= verdict.eq_all;
               cr_lost_q <= verdict.cr_lost;
               state     <= ST_EQ_CMT;
            end
            ST_EQ_CMT: state <= ST_EQ_CMT_W;
            ST_EQ_CMT_W: begin
               if (commit_ack) begin
                  if (commit_err) begin
                     state <= ST_FINISH;
                  end else begin
                     sw_q  <= cfg_swing0;
                     msw_q <= cfg_maxsw;
                     if (eq_ok_q) begin
                        ok_q  <= 1'b1;
                        state <= ST_FINISH;
                     end else if (cr_lost_q) begin
                        state <= ST_FINISH;
                     end else if (int'(tries_q) + 1 >= int'(EQ_MAX_ITERS)) begin
                        state <= ST_FINISH;
                     end else begin
                        tries_q <= tries_q + TRY_W'(1);
                        state   <= ST_EQ_WAIT;
                     end
                  end
               end
            end
            ST_FINISH: begin
               pat_q  <= PAT_OFF;
               done_q <= 1'b1;
               pass_q <= ok_q;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign commit_req = (state == ST_CR_CMT) || (state == ST_EQ_CMT);
   assign rd_req     = (state == ST_CR_RD) || (state == ST_EQ_RD);
   assign pattern    = pat_q;
   assign busy       = (state != ST_IDLE);
   assign done       = done_q;
   assign pass       = pass_q;

endmodule

// File: rtl/ltrain_seq_chk.sv
module ltrain_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       commit_req,
   input logic       commit_ack,
   input logic       commit_err,
   input logic       rd_req,
   input logic       rd_ack,
   input logic       rd_err,
   input logic [1:0] pattern,
   input logic       busy,
   input logic       done,
   input logic       pass
);
   logic cmt_pend;
   logic rd_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmt_pend <= 1'b0;
         rd_pend  <= 1'b0;
      end else begin
         if (commit_req)      cmt_pend <= 1'b1;
         else if (commit_ack) cmt_pend <= 1'b0;
         if (rd_req)          rd_pend  <= 1'b1;
         else if (rd_ack)     rd_pend  <= 1'b0;
      end
   end

   // R1
   start_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (pattern == 2'd1));

   // R3
   pat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pattern == 2'd2 && $past(pattern) != 2'd2) |-> ($past(pattern) == 2'd1));

   // R10
   done_pat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pattern == 2'd0));

   // R10
   pass_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pass) |-> done);

   // R2
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({commit_req, rd_req, done}));

   // R6
   rd_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (pattern != 2'd0));

   // R11
   cmt_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_pend && commit_ack && commit_err) |=> ##1 (done && !pass));

   // R11
   rd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pend && rd_ack && rd_err) |=> ##1 (done && !pass));

endmodule

bind ltrain_seq ltrain_seq_chk chk_i (.*);

// File: tb/ltrain_seq_tb_top.sv
`timescale 1ns/1ps
module ltrain_seq_tb_top;

   localparam int CR_US = 100;
   localparam int EQ_US = 400;

   typedef struct {
      bit    pass;
      int    cmt;
      int    rd1;
      int    rd2;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  lane_num = 3'd4;
   logic        us_tick = 1'b1;
   logic        commit_req;
   logic        commit_ack = 1'b0;
   logic        commit_err = 1'b0;
   logic [1:0]  cfg_swing0 = 2'd0;
   logic [3:0]  cfg_maxsw = 4'd0;
   logic        rd_req;
   logic        rd_ack = 1'b0;
   logic        rd_err = 1'b0;
   logic [47:0] rd_data = '0;
   logic [1:0]  pattern;
   logic        busy;
   logic        done;
   logic        pass;

   logic [47:0] st_scr [0:15];
   logic [1:0]  sw_scr [0:15];
   logic [3:0]  ms_scr [0:15];
   int cerr_at, rerr_at;
   int n_cmt, n_rd1, n_rd2;
   int cyc, last_resp_cyc, last_kind;
   int nchk, nfail;
   exp_t sb[$];

   always #2 clk = ~clk;

   ltrain_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .lane_num(lane_num), .us_tick(us_tick),
      .commit_req(commit_req), .commit_ack(commit_ack), .commit_err(commit_err),
      .cfg_swing0(cfg_swing0), .cfg_maxsw(cfg_maxsw),
      .rd_req(rd_req), .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
      .pattern(pattern), .busy(busy), .done(done), .pass(pass)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(negedge clk) cyc <= cyc + 1;

   // responder for the matcher and the status reader
   initial begin
      forever begin
         @(negedge clk);
         if (commit_req) begin
            automatic int idx = (n_cmt < 16) ? n_cmt : 15;
            if (n_cmt == 0) chk(pattern == 2'd1, "R1 first commit under pattern 1", pattern, 1);
            if (pattern == 2'd2) chk(last_kind == 2, "R6 eq commit follows a read", last_kind, 2);
            n_cmt++;
            repeat (2) @(negedge clk);
            cfg_swing0 = sw_scr[idx];
            cfg_maxsw  = ms_scr[idx];
            commit_err = (idx == cerr_at);
            commit_ack = 1'b1;
            last_resp_cyc = cyc;
            last_kind = 1;
            @(negedge clk);
            commit_ack = 1'b0;
            commit_err = 1'b0;
         end else if (rd_req) begin
            automatic int ri  = n_rd1 + n_rd2;
            automatic int lim = (pattern == 2'd1) ? CR_US : EQ_US;
            automatic int dt  = cyc - last_resp_cyc;
            if (pattern == 2'd1) begin
               chk(dt >= lim && dt <= lim + 6, "R2 clock-recovery wait length", dt, lim);
               n_rd1++;
            end else begin
               chk(dt >= lim && dt <= lim + 6, "R6 equalisation wait length", dt, lim);
               n_rd2++;
            end
            repeat (2) @(negedge clk);
            rd_data = st_scr[(ri < 16) ? ri : 15];
            rd_err  = (ri == rerr_at);
            rd_ack  = 1'b1;
            last_resp_cyc = cyc;
            last_kind = 2;
            @(negedge clk);
            rd_ack = 1'b0;
            rd_err = 1'b0;
         end
      end
   end

   // monitor: compare each finished run against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R10 unexpected done", 1, 0);
            end else begin
               automatic exp_t e = sb.pop_front();
               chk(pass == e.pass, {e.tag, " pass"}, pass, e.pass);
               chk(n_cmt == e.cmt, {e.tag, " commit count"}, n_cmt, e.cmt);
               chk(n_rd1 == e.rd1, {e.tag, " pattern-1 reads"}, n_rd1, e.rd1);
               chk(n_rd2 == e.rd2, {e.tag, " pattern-2 reads"}, n_rd2, e.rd2);
               chk(pattern == 2'd0, {e.tag, " R10 pattern off at done"}, pattern, 0);
            end
         end
      end
   end

   task automatic clr_scr();
      for (int i = 0; i < 16; i++) begin
         st_scr[i] = '0;
         sw_scr[i] = '0;
         ms_scr[i] = '0;
      end
      cerr_at = -1;
      rerr_at = -1;
   endtask

   task automatic run_case(input string tag, input int lanes, input bit ep,
                           input int ecmt, input int erd1, input int erd2);
      automatic exp_t e;
      automatic int guard = 0;
      e.pass = ep; e.cmt = ecmt; e.rd1 = erd1; e.rd2 = erd2; e.tag = tag;
      n_cmt = 0; n_rd1 = 0; n_rd2 = 0;
      sb.push_back(e);
      @(negedge clk);
      lane_num = 3'(lanes);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (sb.size() != 0 && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      if (guard >= 20000) begin
         chk(1'b0, {tag, " run never finished"}, guard, 0);
         void'(sb.pop_front());
      end
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      nchk = 0; nfail = 0; cyc = 0; last_resp_cyc = 0; last_kind = 0;
      n_cmt = 0; n_rd1 = 0; n_rd2 = 0;
      clr_scr();
      repeat (4) @(negedge clk);
      chk(pattern == 2'd0, "R10 reset pattern", pattern, 0);
      chk(!busy && !done && !pass, "R10 reset idle", {busy, done, pass}, 0);
      chk(!commit_req && !rd_req, "R1 reset strobes", {commit_req, rd_req}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 R7: both phases pass first time
      clr_scr();
      st_scr[0] = 48'h0000_0000_1111;
      st_scr[1] = 48'h0000_0001_7777;
      run_case("R3 R7 direct pass", 4, 1'b1, 2, 1, 1);

      // R5: constant swing, clock recovery never locks
      clr_scr();
      run_case("R5 constant swing", 4, 1'b0, 5, 5, 0);

      // R5: swing change on the third commit restarts the count
      clr_scr();
      for (int i = 2; i < 16; i++) sw_scr[i] = 2'd1;
      run_case("R5 swing change", 4, 1'b0, 7, 7, 0);

      // R4: first failing lane (1) is at max swing
      clr_scr();
      for (int i = 0; i < 16; i++) begin
         st_scr[i] = 48'h0000_0000_0001;
         ms_scr[i] = 4'b0010;
      end
      run_case("R4 abort at max swing", 2, 1'b0, 1, 1, 0);

      // R4: max swing only on a lane that already recovered
      clr_scr();
      for (int i = 0; i < 16; i++) begin
         st_scr[i] = 48'h0000_0000_0001;
         ms_scr[i] = 4'b0001;
      end
      run_case("R4 no abort on good lane", 2, 1'b0, 5, 5, 0);

      // R9: equalisation never aligns
      clr_scr();
      for (int i = 0; i < 16; i++) st_scr[i] = 48'h0000_0000_1111;
      run_case("R9 equalisation limit", 4, 1'b0, 7, 1, 6);

      // R8: lane 3 loses clock recovery in equalisation
      clr_scr();
      st_scr[0] = 48'h0000_0000_1111;
      st_scr[1] = 48'h0000_0000_0111;
      run_case("R8 clock recovery lost", 4, 1'b0, 2, 1, 1);

      // R7: align missing on 2nd eq read, present on 3rd
      clr_scr();
      st_scr[0] = 48'h0000_0000_1111;
      st_scr[1] = 48'h0000_0000_1111;
      st_scr[2] = 48'h0000_0000_7777;
      st_scr[3] = 48'h0000_0001_7777;
      run_case("R7 pass on third iteration", 4, 1'b1, 4, 1, 3);

      // R12: one lane, other nibbles zero
      clr_scr();
      st_scr[0] = 48'h0000_0000_0001;
      st_scr[1] = 48'h0000_0001_0007;
      run_case("R12 single lane", 1, 1'b1, 2, 1, 1);

      // R11: commit error on first commit
      clr_scr();
      cerr_at = 0;
      run_case("R11 commit error", 4, 1'b0, 1, 0, 0);

      // R11: read error on first equalisation read
      clr_scr();
      st_scr[0] = 48'h0000_0000_1111;
      rerr_at = 1;
      run_case("R11 read error", 4, 1'b0, 1, 1, 1);

      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule